// File: doc/BRIEF.md
# Byte-Stream Bus Bridge Command Engine

This block sits between a byte-wide serial receiver/transmitter pair and a 32-bit memory-mapped bus master port. It takes whole bytes from the receiver and decodes small command frames. Each frame asks for a run of 32-bit words to be read from the bus or written to it. The bit-level serial logic lives outside. Both byte streams use valid/ready handshakes.

A frame opens with a command byte: 0x02 selects a read and 0x01 selects a write. The next byte is a word count. Four address bytes follow, most significant first. This address is a word address, which is the byte address divided by four. For example, byte address 0x12345678 travels as 0x04 0x8D 0x15 0x9E. A read performs one bus cycle per word and returns each result as four bytes, most significant first. A write frame carries four data bytes per word after the address, and each word goes to the bus as soon as its bytes are complete. If the sender stalls in the middle of a frame for too long, the parser drops the frame and waits for a new command byte.

Top module: `serbus_bridge`

## Requirements
- R1: After reset, rx_ready is 1, tx_valid is 0 and bus_cyc is 0.
- R2: A frame is a command byte (0x02 read, 0x01 write), then a count byte, then four word-address bytes with the most significant byte first.
- R3: During each bus cycle, bus_adr equals the word address shifted left by two, and bus_sel is 4'hF.
- R4: A frame with count N performs exactly N bus cycles. The word address starts at the received value and increases by one after each completed cycle.
- R5: Each read word is sent on tx_data as four bytes, most significant first. tx_valid is never high while bus_cyc is high.
- R6: In a write frame, each word is formed from its four data bytes (most significant first) and written with bus_we=1 and bus_dat_w equal to that word.
- R7: A count of 0 produces no bus cycle and no transmitted byte. The parser then accepts a new frame.
- R8: A byte other than 0x01 or 0x02 in the command position is dropped, and the parser keeps waiting for a command.
- R9: bus_cyc and bus_stb are asserted together and stay high, with bus_adr and bus_we stable, until bus_ack. Only one transfer is outstanding at a time.
- R10: If no byte arrives for TIMEOUT_CYCLES consecutive cycles while a frame is incomplete, the parser returns to waiting for a command byte. A shorter gap leaves the frame intact.
- R11: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged.
- R12: rx_ready is low while a bus cycle or a byte transmission is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Engine accepts a received byte |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Transmitter takes the byte |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_adr | output | 32 | Bus byte address |
| bus_sel | output | 4 | Byte selects |
| bus_dat_w | output | 32 | Bus write data |
| bus_dat_r | input | 32 | Bus read data |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
A read cycle begins on the clock edge that takes the last address byte, or on the edge that drains the previous word's final transmit byte. A write cycle begins on the edge that takes the fourth data byte. The first result byte is presented on the edge after bus_ack. A stall of TIMEOUT_CYCLES idle edges drops the frame. Acknowledge delay and tx_ready are both random, so the bench never waits a fixed number of cycles for a result. It collects each byte and bus transfer at the negative edge before the handshake edge and compares them once the frame has finished. That wait is bounded so that a missing result is reported as a failure. Timeout gaps are chosen well below and well above the limit, so an off-by-one in the cycle count does not decide a check.

// File: rtl/serbus_bridge.sv
`timescale 1ns/1ps
module serbus_bridge #(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        bus_cyc,
  output logic        bus_stb,
  output logic        bus_we,
  output logic [31:0] bus_adr,
  output logic [3:0]  bus_sel,
  output logic [31:0] bus_dat_w,
  input  logic [31:0] bus_dat_r,
  input  logic        bus_ack
);
  localparam int TW = $clog2(TIMEOUT_CYCLES) + 1;
  localparam logic [7:0] CMD_RD = 8'h02;
  localparam logic [7:0] CMD_WR = 8'h01;

  typedef enum logic [2:0] {S_IDLE, S_SIZE, S_ADDR, S_WDAT, S_BUS, S_TX} st_t;

  st_t         st;
  logic        wr;
  logic [7:0]  cnt;
  logic [29:0] waddr;
  logic [31:0] word;
  logic [1:0]  bcnt;
  logic [TW-1:0] tcnt;

  wire waiting = (st == S_SIZE) || (st == S_ADDR) || (st == S_WDAT);
  wire rx_fire = rx_valid && rx_ready;
  wire tx_fire = tx_valid && tx_ready;
  wire expire  = waiting && !rx_fire && (tcnt == TW'(TIMEOUT_CYCLES - 1));

  assign rx_ready  = (st == S_IDLE) || waiting;
  assign bus_cyc   = (st == S_BUS);
  assign bus_stb   = (st == S_BUS);
  assign bus_we    = wr && (st == S_BUS);
  assign bus_adr   = {waddr, 2'b00};
  assign bus_sel   = bus_cyc ? 4'hF : 4'h0;
  assign bus_dat_w = word;
  assign tx_valid  = (st == S_TX);
  assign tx_data   = word[31:24];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wr    <= 1'b0;
      cnt   <= '0;
      waddr <= '0;
      word  <= '0;
      bcnt  <= '0;
      tcnt  <= '0;
    end else begin
      tcnt <= (waiting && !rx_fire) ? tcnt + 1'b1 : '0;
      case (st)
        S_IDLE: if (rx_fire) begin
          bcnt <= '0;
          if (rx_data == CMD_RD) begin wr <= 1'b0; st <= S_SIZE; end
          else if (rx_data == CMD_WR) begin wr <= 1'b1; st <= S_SIZE; end
        end
        S_SIZE: if (rx_fire) begin
          cnt <= rx_data;
          st  <= S_ADDR;
        end
        S_ADDR: if (rx_fire) begin
          waddr <= {waddr[21:0], rx_data};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == 2'd3)
            st <= (cnt == 8'd0) ? S_IDLE : (wr ? S_WDAT : S_BUS);
        end
        S_WDAT: if (rx_fire) begin
          word <= {word[23:0], rx_data};
          bcnt <= bcnt + 1'b1;
          if (bcnt == 2'd3) st <= S_BUS;
        end
        S_BUS: if (bus_ack) begin
          if (!wr) begin
            word <= bus_dat_r;
            st   <= S_TX;
          end else begin
            waddr <= waddr + 1'b1;
            cnt   <= cnt - 1'b1;
            st    <= (cnt == 8'd1) ? S_IDLE : S_WDAT;
          end
        end
        S_TX: if (tx_fire) begin
          word <= {word[23:0], 8'h00};
          bcnt <= bcnt + 1'b1;
          if (bcnt == 2'd3) begin
            waddr <= waddr + 1'b1;
            cnt   <= cnt - 1'b1;
            st    <= (cnt == 8'd1) ? S_IDLE : S_BUS;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (expire) begin
        st   <= S_IDLE;
        tcnt <= '0;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) $rose(rst_n) |-> rx_ready && !tx_valid && !bus_cyc);

  assert_sel_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> bus_sel == 4'hF);

  assert_no_tx_during_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !bus_cyc);

  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ack |=> bus_cyc && bus_stb && $stable(bus_adr) && $stable(bus_we));

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_rx_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc || tx_valid) |-> !rx_ready);
endmodule

// File: tb/tb_serbus_bridge.sv
`timescale 1ns/1ps
module tb_serbus_bridge;
  localparam int TO = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, rx_ready;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready = 1'b0;
  logic bus_cyc, bus_stb, bus_we, bus_ack = 1'b0;
  logic [31:0] bus_adr, bus_dat_w, bus_dat_r = '0;
  logic [3:0] bus_sel;

  serbus_bridge #(.TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_sel(bus_sel), .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r), .bus_ack(bus_ack));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, nbus = 0;
  bit done = 0;
  logic [31:0] mem [0:255];
  logic [31:0] ref_mem [0:255];
  logic [7:0]  tx_q [$];
  logic [31:0] adr_q [$];
  logic [31:0] wdat_q [$];
  logic        we_q [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_adr(input logic [29:0] wa, input int i);
    logic [29:0] a = wa + 30'(i);
    return {a, 2'b00};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [29:0] wa, input int i);
    logic [31:0] w = ref_mem[8'(wa + 30'(i / 4))];
    return w[31 - 8*(i % 4) -: 8];
  endfunction

  // bus slave and transmit sink
  always @(negedge clk) begin
    tx_ready = ($urandom % 2) == 0;
    if (tx_valid && tx_ready) begin
      tx_q.push_back(tx_data);
      check(!bus_cyc, "R5 tx while bus busy", 32'(bus_cyc), 0);
    end
    if (bus_cyc || tx_valid) check(!rx_ready, "R12 rx_ready while busy", 32'(rx_ready), 0);
    bus_ack = bus_cyc && (($urandom % 3) == 0);
    if (bus_ack) begin
      nbus++;
      check(bus_stb, "R9 stb with cyc", 32'(bus_stb), 1);
      check(bus_sel == 4'hF, "R3 byte selects", 32'(bus_sel), 32'hF);
      adr_q.push_back(bus_adr);
      we_q.push_back(bus_we);
      wdat_q.push_back(bus_dat_w);
      if (bus_we) mem[bus_adr[9:2]] = bus_dat_w;
      else bus_dat_r = mem[bus_adr[9:2]];
    end
  end

  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] cmd, input logic [7:0] n, input logic [29:0] wa, input int gap);
    logic [31:0] a = {2'b00, wa};
    send_byte(cmd, 0);
    send_byte(n, gap);
    for (int k = 3; k >= 0; k--) send_byte(a[8*k +: 8], gap);
  endtask

  task automatic clear_logs();
    tx_q.delete(); adr_q.delete(); we_q.delete(); wdat_q.delete(); nbus = 0;
  endtask

  task automatic do_read(input logic [29:0] wa, input int n, input int gap, input string tag);
    int w = 0;
    clear_logs();
    send_hdr(8'h02, 8'(n), wa, gap);
    while (tx_q.size() < 4*n && w < 4000) begin @(negedge clk); w++; end
    repeat (20) @(negedge clk);
    check(tx_q.size() == 4*n, {tag, " R2 byte count"}, tx_q.size(), 4*n);
    check(nbus == n, {tag, " R4 bus cycle count"}, nbus, n);
    for (int i = 0; i < tx_q.size() && i < 4*n; i++)
      check(tx_q[i] == exp_byte(wa, i), {tag, " R5 R11 read byte"}, tx_q[i], exp_byte(wa, i));
    for (int i = 0; i < adr_q.size() && i < n; i++) begin
      check(adr_q[i] == exp_adr(wa, i), {tag, " R3 R4 address"}, adr_q[i], exp_adr(wa, i));
      check(!we_q[i], {tag, " R2 read direction"}, 32'(we_q[i]), 0);
    end
  endtask

  task automatic do_write(input logic [29:0] wa, input int n, input int gap, input string tag);
    logic [31:0] d [$];
    int w = 0;
    clear_logs();
    send_hdr(8'h01, 8'(n), wa, gap);
    for (int i = 0; i < n; i++) begin
      logic [31:0] v = $urandom;
      d.push_back(v);
      ref_mem[8'(wa + 30'(i))] = v;
      for (int k = 3; k >= 0; k--) send_byte(v[8*k +: 8], gap);
    end
    while (nbus < n && w < 4000) begin @(negedge clk); w++; end
    repeat (10) @(negedge clk);
    check(nbus == n, {tag, " R4 write cycle count"}, nbus, n);
    for (int i = 0; i < adr_q.size() && i < n; i++) begin
      check(adr_q[i] == exp_adr(wa, i), {tag, " R3 R4 write address"}, adr_q[i], exp_adr(wa, i));
      check(we_q[i], {tag, " R6 write enable"}, 32'(we_q[i]), 1);
      check(wdat_q[i] == d[i], {tag, " R6 write data"}, wdat_q[i], d[i]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mem[i] = $urandom; ref_mem[i] = mem[i]; end
    repeat (4) @(negedge clk);
    check(rx_ready, "R1 rx_ready in reset", 32'(rx_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_ready && !tx_valid && !bus_cyc, "R1 reset state",
          {29'd0, rx_ready, tx_valid, bus_cyc}, 32'b100);

    do_read(30'h048D159E, 1, 0, "directed");
    do_read(30'h3FFFFFFE, 4, 0, "wrap");
    do_write(30'h00000010, 3, 0, "directed");
    do_read(30'h00000010, 3, 1, "readback R6");

    do_read(30'h00000020, 0, 0, "R7 size0");
    do_read(30'h00000021, 2, 0, "after R7");

    send_byte(8'h55, 0);
    send_byte(8'h7E, 2);
    do_read(30'h00000030, 2, 0, "R8 junk");

    clear_logs();
    send_byte(8'h02, 0);
    send_byte(8'h03, 0);
    repeat (TO + 10) @(negedge clk);
    check(nbus == 0 && tx_q.size() == 0, "R10 dropped frame", nbus, 0);
    do_read(30'h00000040, 1, 0, "R10 after timeout");
    do_read(30'h00000041, 2, TO - 8, "R10 slow");
    do_write(30'h00000050, 1, TO - 8, "R10 slow");
    do_read(30'h00000050, 1, 0, "R10 readback");

    for (int it = 0; it < 24; it++) begin
      logic [29:0] wa = $urandom;
      int n = 1 + ($urandom % 4);
      int g = $urandom % 4;
      if ($urandom % 2) do_write(wa, n, g, "random");
      else do_read(wa, n, g, "random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule